// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between a CPU with a 16-bit address bus and a cartridge carrying up to 128 ROM banks of 16 KiB, up to four external RAM banks of 8 KiB and an optional real-time clock. It watches CPU writes into the lower half of the address space and keeps the banking state from them: which ROM bank fills the switchable window at 0x4000–0x7FFF, which RAM bank fills the window at 0xA000–0xBFFF, and whether that RAM window currently shows RAM, a clock register, or nothing.

The controller does not hold the memories or the clock counters. It produces the translated ROM and RAM addresses, gated RAM read and write strobes, a strobe for writes into a clock register, the index of the selected clock register, and a one-cycle pulse that asks the clock to copy its running counters into its readable copy. When the RAM window shows nothing, the data path outside this block returns 0xFF. Accesses that fall outside the regions it owns are flagged so that other decoders can serve them.

The cartridge configuration (ROM bank count, RAM bank count, clock fitted) comes in on static inputs. Bank counts are powers of two; a count of zero RAM banks means no RAM is fitted.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write is decoded by address bits [15:13]: 0 is the enable register, 1 the ROM bank register, 2 the window select register, 3 the clock latch register; writes with any other value of those bits change no banking state.
- R2: A write to the enable register turns RAM and clock access on when data bits [3:0] equal 0xA and off for any other value.
- R3: A write to the ROM bank register takes data bits [6:0], replaces 0 by 1, then ANDs the result with the ROM bank count minus one.
- R4: For a read in 0x4000–0x7FFF, `rom_sel` is 1 and `rom_addr` equals the ROM bank times 0x4000 plus address bits [13:0].
- R5: A select write of 0x00–0x03 sets the RAM bank to the value ANDed with the RAM bank count minus one and returns the RAM window to RAM; `ram_addr` equals the RAM bank times 0x2000 plus address bits [12:0].
- R6: A select write of 0x08–0x0C, accepted only while the clock is fitted and access is enabled, switches the RAM window to the clock with `clk_idx` equal to the value minus 0x08.
- R7: Select writes of 0x04–0x07 or above 0x0C change neither the RAM bank, the clock index nor the window source.
- R8: `win_src` is 0 for RAM, 1 for clock, 2 for open (reads as 0xFF); it is open when access is disabled, when RAM is shown but no RAM bank is fitted, or when the clock is shown but not fitted.
- R9: After reset the ROM bank is 1, the RAM bank is 0, the clock index is 0, the window shows RAM and access is disabled.
- R10: `ram_we`/`ram_rd` pulse only for accesses in 0xA000–0xBFFF while `win_src` is RAM, and `clk_we` only for writes there while `win_src` is clock.
- R11: `clk_latch` pulses during a write of 0x01 to the latch register when the clock is fitted and the previous latch write (reset counts as a write of 0x00) was 0x00; writes while the clock is absent do not update that history.
- R12: `unclaimed` is 1 for a read outside 0x4000–0x7FFF and 0xA000–0xBFFF, or a write at or above 0x8000 outside 0xA000–0xBFFF, and 0 otherwise, including when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| cfg_rom_banks | input | 8 | Number of ROM banks (power of two, 2..128) |
| cfg_ram_banks | input | 3 | Number of RAM banks (0, 1, 2 or 4) |
| cfg_clk_present | input | 1 | Clock fitted on the cartridge |
| rom_addr | output | 21 | Translated ROM byte address |
| rom_sel | output | 1 | Read of the switchable ROM window |
| ram_addr | output | 15 | Translated RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_rd | output | 1 | RAM read enable |
| win_src | output | 2 | Source of the RAM window: 0 RAM, 1 clock, 2 open |
| clk_idx | output | 3 | Selected clock register (0..4) |
| clk_we | output | 1 | Write into the selected clock register |
| clk_latch | output | 1 | Request to latch the clock counters |
| unclaimed | output | 1 | Access not served by this controller |

## Verification
The assertions take for granted that the configuration inputs do not change in the cycle after a banking write, that bank counts are powers of two, and that a strobe never lasts past one write. The stimulus changes configuration only between accesses, after the result of the previous write has been read, and drives each write strobe for exactly one clock edge, returning it low before the next. Reads are held combinationally between edges, so the window outputs are observed without any register write in flight.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  // Source of data seen in the external RAM window
  typedef enum logic [1:0] {
    SRC_RAM   = 2'd0,
    SRC_CLOCK = 2'd1,
    SRC_OPEN  = 2'd2
  } win_src_e;

  // Control register regions, indexed by address bits [15:13]
  localparam int unsigned RGN_ENABLE = 0;
  localparam int unsigned RGN_ROM    = 1;
  localparam int unsigned RGN_SELECT = 2;
  localparam int unsigned RGN_LATCH  = 3;
  localparam int unsigned N_CTL_RGN  = 4;
endpackage

// File: rtl/cbc_region_decode.sv
module cbc_region_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_CTL  = 4
) (
  input  logic [2:0]       rgn,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  output logic [N_CTL-1:0] ctl_wr,
  output logic             rom_win,
  output logic             ram_win,
  output logic             unclaimed
);
  localparam logic [2:0] RGN_ROM_LO = 3'd2;
  localparam logic [2:0] RGN_ROM_HI = 3'd3;
  localparam logic [2:0] RGN_XRAM   = 3'd5;

  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    assign ctl_wr[g] = cpu_wr && (rgn == 3'(g));
  end

  assign rom_win = (rgn == RGN_ROM_LO) || (rgn == RGN_ROM_HI);
  assign ram_win = (rgn == RGN_XRAM);

  // Writes below the top half always land in a control register
  logic claimed;
  assign claimed   = rom_win || ram_win || (cpu_wr && !rgn[2]);
  assign unclaimed = (cpu_rd || cpu_wr) && !claimed;
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ROM_BANK_W   = 7,
  parameter int unsigned RAM_BANK_W   = 2,
  parameter int unsigned CLK_IDX_W    = 3,
  parameter int unsigned CLK_SEL_BASE = 8,
  parameter int unsigned CLK_REG_CNT  = 5,
  parameter int unsigned N_CTL        = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CTL-1:0]      ctl_wr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [ROM_BANK_W:0]   cfg_rom_banks,
  input  logic [RAM_BANK_W:0]   cfg_ram_banks,
  input  logic                  cfg_clk_present,
  output logic                  en_q,
  output logic [ROM_BANK_W-1:0] rom_bank_q,
  output logic [RAM_BANK_W-1:0] ram_bank_q,
  output logic                  clk_mode_q,
  output logic [CLK_IDX_W-1:0]  clk_idx_q,
  output logic                  latch_pulse
);
  import cbc_pkg::*;

  localparam logic [DATA_W-1:0] RAM_SEL_END = DATA_W'(1 << RAM_BANK_W);
  localparam logic [DATA_W-1:0] CLK_SEL_LO  = DATA_W'(CLK_SEL_BASE);
  localparam logic [DATA_W-1:0] CLK_SEL_HI  = DATA_W'(CLK_SEL_BASE + CLK_REG_CNT - 1);
  localparam logic [3:0]        EN_KEY      = 4'hA;
  localparam logic [DATA_W-1:0] LATCH_ARM   = DATA_W'(0);
  localparam logic [DATA_W-1:0] LATCH_FIRE  = DATA_W'(1);

  logic                  en_d, clk_mode_d, last_zero_d, last_zero_q;
  logic [ROM_BANK_W-1:0] rom_bank_d, rom_mask, rom_pick;
  logic [RAM_BANK_W-1:0] ram_bank_d, ram_mask;
  logic [CLK_IDX_W-1:0]  clk_idx_d;
  logic                  sel_ram, sel_clk;
  logic                  ld_en, ld_rom, ld_sel, ld_latch;

  // Clock enables per register group
  assign ld_en    = ctl_wr[RGN_ENABLE];
  assign ld_rom   = ctl_wr[RGN_ROM];
  assign ld_sel   = ctl_wr[RGN_SELECT];
  assign ld_latch = ctl_wr[RGN_LATCH] && cfg_clk_present;

  assign rom_mask = ROM_BANK_W'(cfg_rom_banks - 1'b1);
  assign ram_mask = RAM_BANK_W'(cfg_ram_banks - 1'b1);
  assign rom_pick = (wdata[ROM_BANK_W-1:0] == '0) ? ROM_BANK_W'(1) : wdata[ROM_BANK_W-1:0];
  assign sel_ram  = (wdata < RAM_SEL_END);
  assign sel_clk  = (wdata >= CLK_SEL_LO) && (wdata <= CLK_SEL_HI);

  always_comb begin
    en_d        = en_q;
    rom_bank_d  = rom_bank_q;
    ram_bank_d  = ram_bank_q;
    clk_mode_d  = clk_mode_q;
    clk_idx_d   = clk_idx_q;
    last_zero_d = last_zero_q;
    if (ld_en)  en_d = (wdata[3:0] == EN_KEY);
    if (ld_rom) rom_bank_d = rom_pick & rom_mask;
    if (ld_sel) begin
      if (sel_clk) begin
        if (cfg_clk_present && en_q) begin
          clk_mode_d = 1'b1;
          clk_idx_d  = CLK_IDX_W'(wdata - CLK_SEL_LO);
        end
      end else if (sel_ram) begin
        clk_mode_d = 1'b0;
        ram_bank_d = wdata[RAM_BANK_W-1:0] & ram_mask;
      end
    end
    if (ld_latch) last_zero_d = (wdata == LATCH_ARM);
  end

  assign latch_pulse = ld_latch && last_zero_q && (wdata == LATCH_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      rom_bank_q  <= ROM_BANK_W'(1);
      ram_bank_q  <= '0;
      clk_mode_q  <= 1'b0;
      clk_idx_q   <= '0;
      last_zero_q <= 1'b1;
    end else begin
      en_q        <= en_d;
      rom_bank_q  <= rom_bank_d;
      ram_bank_q  <= ram_bank_d;
      clk_mode_q  <= clk_mode_d;
      clk_idx_q   <= clk_idx_d;
      last_zero_q <= last_zero_d;
    end
  end
endmodule

// File: rtl/cbc_window_map.sv
module cbc_window_map #(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned ROM_WIN_W  = 14,
  parameter int unsigned RAM_WIN_W  = 13
) (
  input  logic [ROM_WIN_W-1:0]           rom_off,
  input  logic [RAM_WIN_W-1:0]           ram_off,
  input  logic                           cpu_wr,
  input  logic                           cpu_rd,
  input  logic                           rom_win,
  input  logic                           ram_win,
  input  logic                           en_q,
  input  logic [ROM_BANK_W-1:0]          rom_bank_q,
  input  logic [RAM_BANK_W-1:0]          ram_bank_q,
  input  logic                           clk_mode_q,
  input  logic                           ram_fitted,
  input  logic                           cfg_clk_present,
  output logic [ROM_BANK_W+ROM_WIN_W-1:0] rom_addr,
  output logic                           rom_sel,
  output logic [RAM_BANK_W+RAM_WIN_W-1:0] ram_addr,
  output cbc_pkg::win_src_e              win_src,
  output logic                           ram_we,
  output logic                           ram_rd,
  output logic                           clk_we
);
  import cbc_pkg::*;

  assign rom_addr = {rom_bank_q, rom_off};
  assign ram_addr = {ram_bank_q, ram_off};
  assign rom_sel  = cpu_rd && rom_win;

  always_comb begin
    if (!en_q)           win_src = SRC_OPEN;
    else if (clk_mode_q) win_src = cfg_clk_present ? SRC_CLOCK : SRC_OPEN;
    else                 win_src = ram_fitted ? SRC_RAM : SRC_OPEN;
  end

  assign ram_we = cpu_wr && ram_win && (win_src == SRC_RAM);
  assign ram_rd = cpu_rd && ram_win && (win_src == SRC_RAM);
  assign clk_we = cpu_wr && ram_win && (win_src == SRC_CLOCK);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned ROM_WIN_W  = 14,
  parameter int unsigned RAM_WIN_W  = 13,
  parameter int unsigned CLK_IDX_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  input  logic                           cpu_wr,
  input  logic                           cpu_rd,
  input  logic [ROM_BANK_W:0]            cfg_rom_banks,
  input  logic [RAM_BANK_W:0]            cfg_ram_banks,
  input  logic                           cfg_clk_present,
  output logic [ROM_BANK_W+ROM_WIN_W-1:0] rom_addr,
  output logic                           rom_sel,
  output logic [RAM_BANK_W+RAM_WIN_W-1:0] ram_addr,
  output logic                           ram_we,
  output logic                           ram_rd,
  output logic [1:0]                     win_src,
  output logic [CLK_IDX_W-1:0]           clk_idx,
  output logic                           clk_we,
  output logic                           clk_latch,
  output logic                           unclaimed
);
  import cbc_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [N_CTL_RGN-1:0]  ctl_wr;
  logic                  rom_win, ram_win, en_q, clk_mode_q;
  logic [ROM_BANK_W-1:0] rom_bank_q;
  logic [RAM_BANK_W-1:0] ram_bank_q;
  win_src_e              src;

  cbc_region_decode #(.ADDR_W(ADDR_W), .N_CTL(N_CTL_RGN)) u_dec (
    .rgn(cpu_addr[ADDR_W-1 -: 3]), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .ctl_wr(ctl_wr), .rom_win(rom_win), .ram_win(ram_win), .unclaimed(unclaimed)
  );

  cbc_bank_regs #(
    .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .CLK_IDX_W(CLK_IDX_W), .CLK_SEL_BASE(8), .CLK_REG_CNT(5), .N_CTL(N_CTL_RGN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_int), .ctl_wr(ctl_wr), .wdata(cpu_wdata),
    .cfg_rom_banks(cfg_rom_banks), .cfg_ram_banks(cfg_ram_banks),
    .cfg_clk_present(cfg_clk_present), .en_q(en_q), .rom_bank_q(rom_bank_q),
    .ram_bank_q(ram_bank_q), .clk_mode_q(clk_mode_q), .clk_idx_q(clk_idx),
    .latch_pulse(clk_latch)
  );

  cbc_window_map #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W)
  ) u_map (
    .rom_off(cpu_addr[ROM_WIN_W-1:0]), .ram_off(cpu_addr[RAM_WIN_W-1:0]),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_win(rom_win), .ram_win(ram_win),
    .en_q(en_q), .rom_bank_q(rom_bank_q), .ram_bank_q(ram_bank_q),
    .clk_mode_q(clk_mode_q), .ram_fitted(cfg_ram_banks != '0),
    .cfg_clk_present(cfg_clk_present), .rom_addr(rom_addr), .rom_sel(rom_sel),
    .ram_addr(ram_addr), .win_src(src), .ram_we(ram_we), .ram_rd(ram_rd),
    .clk_we(clk_we)
  );

  assign win_src = src;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned ROM_WIN_W  = 14,
  parameter int unsigned RAM_WIN_W  = 13,
  parameter int unsigned CLK_IDX_W  = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              cpu_addr,
  input logic [DATA_W-1:0]              cpu_wdata,
  input logic                           cpu_wr,
  input logic [ROM_BANK_W:0]            cfg_rom_banks,
  input logic [RAM_BANK_W:0]            cfg_ram_banks,
  input logic [ROM_BANK_W+ROM_WIN_W-1:0] rom_addr,
  input logic                           rom_sel,
  input logic [RAM_BANK_W+RAM_WIN_W-1:0] ram_addr,
  input logic                           ram_we,
  input logic                           ram_rd,
  input logic [1:0]                     win_src,
  input logic [CLK_IDX_W-1:0]           clk_idx,
  input logic                           clk_we,
  input logic                           clk_latch,
  input logic                           unclaimed
);
  logic [2:0] rgn;
  assign rgn = cpu_addr[ADDR_W-1 -: 3];

  // R2: a non-key enable write leaves the window open
  a_r2_disable_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rgn == 3'd0 && cpu_wdata[3:0] != 4'hA) |=> (win_src == 2'd2));

  // R3: zero written to the ROM bank register maps bank 1
  a_r3_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rgn == 3'd1 && cpu_wdata[ROM_BANK_W-1:0] == '0 && cfg_rom_banks > 1)
    |=> (rom_addr[ROM_BANK_W+ROM_WIN_W-1 -: ROM_BANK_W] == ROM_BANK_W'(1)));

  // R5: RAM bank select is masked by the fitted bank count
  a_r5_ram_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rgn == 3'd2 && cpu_wdata < DATA_W'(1 << RAM_BANK_W))
    |=> (ram_addr[RAM_BANK_W+RAM_WIN_W-1 -: RAM_BANK_W] ==
         ($past(cpu_wdata[RAM_BANK_W-1:0]) & RAM_BANK_W'($past(cfg_ram_banks) - 1'b1))));

  // R7: out-of-range select values change nothing
  a_r7_ignored_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rgn == 3'd2 &&
     ((cpu_wdata > DATA_W'(3) && cpu_wdata < DATA_W'(8)) || cpu_wdata > DATA_W'(12)))
    |=> ($stable(ram_addr[RAM_BANK_W+RAM_WIN_W-1 -: RAM_BANK_W]) &&
         $stable(clk_idx) && $stable(win_src)));

  // R10: after disabling, the window raises no strobe
  a_r10_no_strobe_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && rgn == 3'd0 && cpu_wdata[3:0] != 4'hA) |=> (!ram_we && !ram_rd && !clk_we));

  // R11: a latch request never lasts two cycles
  a_r11_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    clk_latch |=> !clk_latch);

  // R12: unclaimed accesses drive no memory strobe
  a_r12_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unclaimed |-> (!ram_we && !ram_rd && !clk_we && !rom_sel));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
  .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W), .CLK_IDX_W(CLK_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_int), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cfg_rom_banks(cfg_rom_banks), .cfg_ram_banks(cfg_ram_banks),
  .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_addr(ram_addr), .ram_we(ram_we),
  .ram_rd(ram_rd), .win_src(win_src), .clk_idx(clk_idx), .clk_we(clk_we),
  .clk_latch(clk_latch), .unclaimed(unclaimed)
);

// File: tb/cart_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cart_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr, cpu_rd;
  logic [7:0]  cfg_rom_banks;
  logic [2:0]  cfg_ram_banks;
  logic        cfg_clk_present;
  logic [20:0] rom_addr;
  logic        rom_sel;
  logic [14:0] ram_addr;
  logic        ram_we, ram_rd;
  logic [1:0]  win_src;
  logic [2:0]  clk_idx;
  logic        clk_we, clk_latch, unclaimed;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic s_we, s_clkwe, s_latch, s_uncl;

  always #4 clk = ~clk;

  cart_bank_ctrl u_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cfg_rom_banks(cfg_rom_banks),
    .cfg_ram_banks(cfg_ram_banks), .cfg_clk_present(cfg_clk_present),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_rd(ram_rd), .win_src(win_src), .clk_idx(clk_idx), .clk_we(clk_we),
    .clk_latch(clk_latch), .unclaimed(unclaimed)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] ra;
    logic [1:0]  src;
    logic [20:0] addr;
    logic [2:0]  idx;
  } vec_t;

  // write, then read back; cfg: 128 ROM banks, 4 RAM banks, clock fitted
  localparam vec_t TABLE [14] = '{
    '{4'd3,  16'h2000, 8'h00, 16'h4123, 2'd2, 21'h004123, 3'd0}, // R3 zero -> 1
    '{4'd4,  16'h2000, 8'h05, 16'h7FFF, 2'd2, 21'h017FFF, 3'd0}, // R4 bank 5
    '{4'd3,  16'h2000, 8'hFF, 16'h4000, 2'd2, 21'h1FC000, 3'd0}, // R3 7 bits
    '{4'd2,  16'h0000, 8'h0A, 16'hA010, 2'd0, 21'h000010, 3'd0}, // R2 enable
    '{4'd5,  16'h4000, 8'h03, 16'hBFFF, 2'd0, 21'h007FFF, 3'd0}, // R5 bank 3
    '{4'd6,  16'h4000, 8'h0A, 16'hA000, 2'd1, 21'h006000, 3'd2}, // R6 clock 2
    '{4'd7,  16'h4000, 8'h05, 16'hA000, 2'd1, 21'h006000, 3'd2}, // R7 ignored
    '{4'd2,  16'h0000, 8'h1B, 16'hA000, 2'd2, 21'h006000, 3'd2}, // R2 disable
    '{4'd2,  16'h0000, 8'hFA, 16'hA000, 2'd1, 21'h006000, 3'd2}, // R2 low nibble
    '{4'd5,  16'h4000, 8'h01, 16'hA001, 2'd0, 21'h002001, 3'd2}, // R5 back to RAM
    '{4'd7,  16'h4000, 8'h0D, 16'hA001, 2'd0, 21'h002001, 3'd2}, // R7 above range
    '{4'd8,  16'h0000, 8'h00, 16'hA000, 2'd2, 21'h002000, 3'd2}, // R8 open
    '{4'd6,  16'h4000, 8'h0C, 16'hA000, 2'd2, 21'h002000, 3'd2}, // R6 refused
    '{4'd6,  16'h0000, 8'h0A, 16'hA000, 2'd0, 21'h002000, 3'd2}  // R6 still RAM
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    s_we = ram_we; s_clkwe = clk_we; s_latch = clk_latch; s_uncl = unclaimed;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  vec_t v;

  initial begin
    cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    cfg_rom_banks = 8'd128; cfg_ram_banks = 3'd4; cfg_clk_present = 1'b1;
    rst_n = 1'b0;
    do_reset();

    // R9 reset state
    rd(16'h4000);
    chk("R9 rom bank after reset", 32'(rom_addr), 32'h4000);
    chk("R9 window open after reset", 32'(win_src), 32'd2);
    chk("R9 clock index after reset", 32'(clk_idx), 32'd0);
    rd(16'hA000);
    chk("R9 ram bank after reset", 32'(ram_addr), 32'h0);

    for (int i = 0; i < 14; i++) begin
      v = TABLE[i];
      wr(v.wa, v.wd);
      rd(v.ra);
      chk($sformatf("R%0d vector %0d source", v.req, i), 32'(win_src), 32'(v.src));
      chk($sformatf("R%0d vector %0d address", v.req, i),
          v.ra[15:14] == 2'b01 ? 32'(rom_addr) : 32'(ram_addr), 32'(v.addr));
      chk($sformatf("R%0d vector %0d clock index", v.req, i), 32'(clk_idx), 32'(v.idx));
    end

    // R1 latch-region and high writes leave banking alone
    wr(16'h6000, 8'h0A);
    wr(16'hC000, 8'h00);
    wr(16'h8000, 8'h03);
    rd(16'hA000);
    chk("R1 window unchanged", 32'(win_src), 32'd0);
    chk("R1 ram bank unchanged", 32'(ram_addr), 32'h2000);
    rd(16'h4000);
    chk("R1 rom bank unchanged", 32'(rom_addr), 32'h1FC000);
    chk("R4 rom_sel on window read", 32'(rom_sel), 32'd1);

    // R10 write strobe gating
    wr(16'hA005, 8'h55);
    chk("R10 ram_we when enabled", 32'(s_we), 32'd1);
    wr(16'h0000, 8'h00);
    wr(16'hA005, 8'h55);
    chk("R10 no ram_we when disabled", 32'(s_we), 32'd0);
    wr(16'h0000, 8'h0A);

    // R8 no RAM fitted
    cfg_ram_banks = 3'd0;
    rd(16'hA000);
    chk("R8 open with no RAM", 32'(win_src), 32'd2);
    wr(16'hA000, 8'h12);
    chk("R10 no ram_we with no RAM", 32'(s_we), 32'd0);
    cfg_ram_banks = 3'd4;

    // R5 RAM bank mask with 2 banks
    cfg_ram_banks = 3'd2;
    wr(16'h4000, 8'h02);
    rd(16'hA000);
    chk("R5 ram bank masked", 32'(ram_addr), 32'h0000);
    cfg_ram_banks = 3'd4;

    // R3 ROM bank mask with 8 banks
    cfg_rom_banks = 8'd8;
    wr(16'h2000, 8'h0B);
    rd(16'h4000);
    chk("R3 rom bank masked", 32'(rom_addr), 32'h0C000);
    wr(16'h2000, 8'h00);
    rd(16'h4000);
    chk("R3 zero becomes one", 32'(rom_addr), 32'h04000);
    wr(16'h2000, 8'h08);
    rd(16'h4000);
    chk("R3 mask may give bank 0", 32'(rom_addr), 32'h00000);
    cfg_rom_banks = 8'd128;

    // R6 clock absent refuses selection
    cfg_clk_present = 1'b0;
    wr(16'h4000, 8'h09);
    rd(16'hA000);
    chk("R6 no clock keeps RAM", 32'(win_src), 32'd0);
    chk("R6 no clock keeps index", 32'(clk_idx), 32'd2);
    cfg_clk_present = 1'b1;

    // R6 and R10 clock register writes
    wr(16'h4000, 8'h09);
    rd(16'hA000);
    chk("R6 clock selected", 32'(win_src), 32'd1);
    chk("R6 clock index 1", 32'(clk_idx), 32'd1);
    wr(16'hA000, 8'h11);
    chk("R10 clk_we in clock mode", 32'(s_clkwe), 32'd1);
    chk("R10 no ram_we in clock mode", 32'(s_we), 32'd0);

    // R8 clock removed while shown
    cfg_clk_present = 1'b0;
    rd(16'hA000);
    chk("R8 open without clock", 32'(win_src), 32'd2);
    cfg_clk_present = 1'b1;

    // R11 latch sequence
    wr(16'h6000, 8'h00);
    chk("R11 no latch on 0", 32'(s_latch), 32'd0);
    wr(16'h6000, 8'h01);
    chk("R11 latch on 0 then 1", 32'(s_latch), 32'd1);
    wr(16'h6000, 8'h01);
    chk("R11 no latch on 1 then 1", 32'(s_latch), 32'd0);
    wr(16'h6000, 8'h00);
    cfg_clk_present = 1'b0;
    wr(16'h6000, 8'h01);
    chk("R11 no latch without clock", 32'(s_latch), 32'd0);
    cfg_clk_present = 1'b1;
    wr(16'h6000, 8'h01);
    chk("R11 history kept while absent", 32'(s_latch), 32'd1);

    // R12 unclaimed
    rd(16'hC000);
    chk("R12 high read unclaimed", 32'(unclaimed), 32'd1);
    rd(16'h0100);
    chk("R12 fixed bank read unclaimed", 32'(unclaimed), 32'd1);
    rd(16'h5000);
    chk("R12 rom window claimed", 32'(unclaimed), 32'd0);
    wr(16'h2000, 8'h01);
    chk("R12 control write claimed", 32'(s_uncl), 32'd0);
    wr(16'hE000, 8'h00);
    chk("R12 high write unclaimed", 32'(s_uncl), 32'd1);
    cpu_rd = 1'b0;
    #1;
    chk("R12 idle not unclaimed", 32'(unclaimed), 32'd0);

    // R9 reset mid-run
    do_reset();
    rd(16'h4000);
    chk("R9 rom bank after second reset", 32'(rom_addr), 32'h4000);
    chk("R9 disabled after second reset", 32'(win_src), 32'd2);
    chk("R9 index after second reset", 32'(clk_idx), 32'd0);
    rd(16'hA000);
    chk("R9 ram bank after second reset", 32'(ram_addr), 32'h0);
    wr(16'h0000, 8'h0A);
    rd(16'hA000);
    chk("R9 window shows RAM after reset", 32'(win_src), 32'd0);
    wr(16'h6000, 8'h01);
    chk("R11 reset arms latch", 32'(s_latch), 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule